// File: doc/BRIEF.md
# Host-Windowed Shared Memory Interface

This block lets an external host reach a region of local memory through a small I/O window of sixteen byte registers. The host first loads a 16-bit pointer into two offset registers and then touches one of four data registers. Data register n reaches the local byte at base plus pointer plus n. The block turns each such data access into a single request on a simple local memory port. The block also keeps a mailbox byte that the host writes to signal the local side, and a byte that the local side leaves for the host to read.

The region is guarded by two independent upper limits, one for reads and one for writes. With the read limit at 0x200 and the write limit at 0x100, the host can read and write the lower 256 bytes. The next 256 bytes are read-only to it, and the host sees nothing beyond them. A refused read returns 0xFF. A refused write is dropped and leaves a sticky flag for the local side.

The host interface is a one-cycle strobe with address, direction and write byte. The block answers with a one-cycle done pulse, and the read byte is valid while that pulse is high. The host issues no new strobe until done has been seen.

Top module: `hwin_shmem`

## Requirements
- R1: Register indexes are host_addr_i[3:0]. Indexes 8 to 15 are unmapped: a read of one returns 0x00 and a write to one changes no state.
- R2: Index 2 holds bits 7:0 and index 3 holds bits 15:8 of the 16-bit pointer. Both can be written and read back by the host.
- R3: A data access at index 4+n (n = 0..3) uses effective offset (pointer + n) mod 65536. An accepted access requests local address base_i + effective offset.
- R4: A data read is accepted only when effective offset < rd_limit_i. A refused read returns 0xFF and issues no memory request.
- R5: A data write is accepted only when effective offset < wr_limit_i. A refused write issues no request and sets wr_viol_o. The flag stays set until viol_clr_i, and a new violation in the same cycle wins over the clear.
- R6: An accepted data access drives mem_req_o high for exactly one cycle, the cycle after the strobe. host_done_o rises in the cycle after mem_ready_i is first sampled high, which may be in the request cycle itself. For reads, host_rdata_o then holds mem_rdata_i.
- R7: Every access that needs no memory request completes with host_done_o in the cycle after the strobe.
- R8: A host write to index 0 stores the byte on h2l_data_o and sets mbox_irq_o. mbox_irq_o stays high until mbox_ack_i, and a new write in the same cycle wins over the acknowledge. A host read of index 0 returns the stored byte.
- R9: A host read of index 1 returns the last byte loaded by l2h_we_i/l2h_data_i. Host writes to index 1 are ignored.
- R10: After reset the pointer, both mailbox bytes, mbox_irq_o, wr_viol_o, mem_req_o and host_done_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_sel_i | input | 1 | One-cycle host access strobe |
| host_we_i | input | 1 | 1 = host write, 0 = host read |
| host_addr_i | input | 4 | Window register index |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Host read byte, valid with host_done_o |
| host_done_o | output | 1 | Access complete pulse |
| base_i | input | AW | Local base address of the region |
| rd_limit_i | input | 16 | Host read upper limit (exclusive) |
| wr_limit_i | input | 16 | Host write upper limit (exclusive) |
| h2l_data_o | output | 8 | Host-to-local mailbox byte |
| mbox_irq_o | output | 1 | Mailbox interrupt to the local side |
| mbox_ack_i | input | 1 | Clears mbox_irq_o |
| l2h_we_i | input | 1 | Local load of the local-to-host byte |
| l2h_data_i | input | 8 | Local-to-host byte |
| wr_viol_o | output | 1 | Sticky refused-write flag |
| viol_clr_i | input | 1 | Clears wr_viol_o |
| mem_req_o | output | 1 | Local memory request, one cycle |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Local memory byte address |
| mem_wdata_o | output | 8 | Local memory write byte |
| mem_rdata_i | input | 8 | Local memory read byte, valid with mem_ready_i |
| mem_ready_i | input | 1 | Local memory completion |

## Verification
Register accesses and refused data accesses finish one cycle after the strobe. Accepted data accesses raise the request one cycle after the strobe and finish one cycle after ready. Mailbox interrupt, violation flag and pointer change at the same edge that samples the strobe. The bench holds a behavioural model that steps on each rising edge from the inputs the bench drove before that edge. It compares done, read byte, request, request address and the side-band outputs shortly after every edge. The memory responder answers with a varying ready delay (0, 1 and 3 cycles), so the due cycle moves with it and the model follows the delay rather than assuming one.

// File: rtl/hwin_pkg.sv
`timescale 1ns/1ps
package hwin_pkg;
  localparam int unsigned OW = 16;  // pointer width, two host bytes
  localparam int unsigned DW = 8;

  localparam logic [3:0] IDX_H2L    = 4'd0;
  localparam logic [3:0] IDX_L2H    = 4'd1;
  localparam logic [3:0] IDX_OFS_LO = 4'd2;
  localparam logic [3:0] IDX_OFS_HI = 4'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} mem_st_e;
endpackage

// File: rtl/hwin_decode.sv
`timescale 1ns/1ps
module hwin_decode
  import hwin_pkg::*;
(
  input  logic [3:0]    addr_i,
  input  logic          we_i,
  input  logic [OW-1:0] ofs_i,
  input  logic [OW-1:0] rd_limit_i,
  input  logic [OW-1:0] wr_limit_i,
  output logic          is_data_o,
  output logic [OW-1:0] eff_o,
  output logic          ok_o
);
  assign is_data_o = (addr_i[3:2] == 2'b01);
  assign eff_o     = ofs_i + {{(OW-2){1'b0}}, addr_i[1:0]};
  assign ok_o      = we_i ? (eff_o < wr_limit_i) : (eff_o < rd_limit_i);
endmodule

// File: rtl/hwin_regs.sv
`timescale 1ns/1ps
module hwin_regs
  import hwin_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [3:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          l2h_we_i,
  input  logic [DW-1:0] l2h_data_i,
  input  logic          ack_i,
  input  logic          viol_set_i,
  input  logic          viol_clr_i,
  output logic [OW-1:0] ofs_o,
  output logic [DW-1:0] h2l_o,
  output logic [DW-1:0] l2h_o,
  output logic          irq_o,
  output logic          viol_o
);
  logic mb_wr;
  assign mb_wr = wr_en_i && (addr_i == IDX_H2L);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_o  <= '0;
      h2l_o  <= '0;
      l2h_o  <= '0;
      irq_o  <= 1'b0;
      viol_o <= 1'b0;
    end else begin
      if (wr_en_i && addr_i == IDX_OFS_LO) ofs_o[7:0]  <= wdata_i;
      if (wr_en_i && addr_i == IDX_OFS_HI) ofs_o[15:8] <= wdata_i;
      if (mb_wr) h2l_o <= wdata_i;
      if (l2h_we_i) l2h_o <= l2h_data_i;
      if (mb_wr)       irq_o <= 1'b1;
      else if (ack_i)  irq_o <= 1'b0;
      if (viol_set_i)      viol_o <= 1'b1;
      else if (viol_clr_i) viol_o <= 1'b0;
    end
  end

  AST_IRQ_ON_MBOX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mb_wr |=> irq_o); // R8
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_i) |=> irq_o); // R8
  AST_VIOL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_o && !viol_clr_i) |=> viol_o); // R5
  AST_VIOL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_set_i |=> viol_o); // R5
endmodule

// File: rtl/hwin_mem_fsm.sv
`timescale 1ns/1ps
module hwin_mem_fsm
  import hwin_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          mem_ready_i,
  output logic          idle_o,
  output logic          fin_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o
);
  mem_st_e st_q;

  assign idle_o    = (st_q == ST_IDLE);
  assign mem_req_o = (st_q == ST_REQ);
  assign fin_o     = !idle_o && mem_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q        <= ST_REQ;
          mem_we_o    <= we_i;
          mem_addr_o  <= addr_i;
          mem_wdata_o <= wdata_i;
        end
        ST_REQ:  st_q <= mem_ready_i ? ST_IDLE : ST_WAIT;
        ST_WAIT: if (mem_ready_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o); // R6
  AST_REQ_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && idle_o) |=> mem_req_o); // R6
endmodule

// File: rtl/hwin_shmem.sv
`timescale 1ns/1ps
module hwin_shmem
  import hwin_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_sel_i,
  input  logic          host_we_i,
  input  logic [3:0]    host_addr_i,
  input  logic [7:0]    host_wdata_i,
  output logic [7:0]    host_rdata_o,
  output logic          host_done_o,
  input  logic [AW-1:0] base_i,
  input  logic [15:0]   rd_limit_i,
  input  logic [15:0]   wr_limit_i,
  output logic [7:0]    h2l_data_o,
  output logic          mbox_irq_o,
  input  logic          mbox_ack_i,
  input  logic          l2h_we_i,
  input  logic [7:0]    l2h_data_i,
  output logic          wr_viol_o,
  input  logic          viol_clr_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i,
  input  logic          mem_ready_i
);
  logic [OW-1:0] ofs, eff;
  logic [DW-1:0] h2l, l2h, rd_mux;
  logic          is_data, acc_ok, idle, fin, acc, mem_go, reg_acc, viol_set;

  hwin_decode u_dec (
    .addr_i(host_addr_i), .we_i(host_we_i), .ofs_i(ofs),
    .rd_limit_i(rd_limit_i), .wr_limit_i(wr_limit_i),
    .is_data_o(is_data), .eff_o(eff), .ok_o(acc_ok)
  );

  assign acc      = host_sel_i && idle;
  assign mem_go   = acc && is_data && acc_ok;
  assign reg_acc  = acc && !(is_data && acc_ok);
  assign viol_set = acc && is_data && host_we_i && !acc_ok;

  hwin_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(acc && host_we_i), .addr_i(host_addr_i), .wdata_i(host_wdata_i),
    .l2h_we_i(l2h_we_i), .l2h_data_i(l2h_data_i), .ack_i(mbox_ack_i),
    .viol_set_i(viol_set), .viol_clr_i(viol_clr_i),
    .ofs_o(ofs), .h2l_o(h2l), .l2h_o(l2h), .irq_o(mbox_irq_o), .viol_o(wr_viol_o)
  );

  hwin_mem_fsm #(.AW(AW)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(mem_go), .we_i(host_we_i),
    .addr_i(base_i + {{(AW-OW){1'b0}}, eff}), .wdata_i(host_wdata_i),
    .mem_ready_i(mem_ready_i), .idle_o(idle), .fin_o(fin),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
  );

  always_comb begin
    unique case (host_addr_i)
      IDX_H2L:    rd_mux = h2l;
      IDX_L2H:    rd_mux = l2h;
      IDX_OFS_LO: rd_mux = ofs[7:0];
      IDX_OFS_HI: rd_mux = ofs[15:8];
      default:    rd_mux = is_data ? 8'hFF : 8'h00;  // refused data read
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_done_o  <= 1'b0;
      host_rdata_o <= '0;
    end else begin
      host_done_o <= reg_acc || fin;
      if (fin)          host_rdata_o <= mem_rdata_i;
      else if (reg_acc) host_rdata_o <= rd_mux;
    end
  end

  assign h2l_data_o = h2l;

  AST_REG_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_acc |=> host_done_o); // R7
  AST_NO_REQ_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && is_data && !acc_ok) |=> !mem_req_o); // R4
  AST_FIN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_ready_i && !idle) |=> host_done_o); // R6
endmodule

// File: tb/hwin_shmem_bench.sv
`timescale 1ns/1ps
module hwin_shmem_bench;
  localparam int AW = 16;
  localparam logic [15:0] BASE = 16'h0200;
  localparam logic [15:0] RLIM = 16'h0200;
  localparam logic [15:0] WLIM = 16'h0100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 0, we = 0, ack = 0, l2h_we = 0, vclr = 0;
  logic [3:0] addr = 0;
  logic [7:0] wd = 0, l2h_d = 0, mrd = 0;
  logic mrdy = 0;
  logic [7:0] rdata, h2l, mwd;
  logic done, irq, viol, mreq, mwe;
  logic [AW-1:0] maddr;

  always #2.5 clk = ~clk;

  hwin_shmem #(.AW(AW)) u_hwin_shmem (
    .clk_i(clk), .rst_ni(rst_n),
    .host_sel_i(sel), .host_we_i(we), .host_addr_i(addr), .host_wdata_i(wd),
    .host_rdata_o(rdata), .host_done_o(done),
    .base_i(BASE), .rd_limit_i(RLIM), .wr_limit_i(WLIM),
    .h2l_data_o(h2l), .mbox_irq_o(irq), .mbox_ack_i(ack),
    .l2h_we_i(l2h_we), .l2h_data_i(l2h_d),
    .wr_viol_o(viol), .viol_clr_i(vclr),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_wdata_o(mwd),
    .mem_rdata_i(mrd), .mem_ready_i(mrdy)
  );

  int checks = 0, fails = 0, cycles = 0;
  logic [7:0] bmem [2048];
  logic [7:0] shadow [2048];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // memory responder
  int delay = 0, cnt = 0;
  logic pend = 0, p_we = 0;
  logic [AW-1:0] p_a = 0;
  logic [7:0] p_d = 0;
  always @(negedge clk) begin
    mrdy = 1'b0;
    if (mreq) begin pend = 1; cnt = delay; p_we = mwe; p_a = maddr; p_d = mwd; end
    if (pend) begin
      if (cnt == 0) begin
        mrdy = 1'b1; mrd = bmem[p_a[10:0]];
        if (p_we) bmem[p_a[10:0]] = p_d;
        pend = 0;
      end else cnt--;
    end
  end

  // reference model, stepped from the inputs driven before each edge
  int ph = 0;
  logic e_done = 0, e_rd = 0, e_req = 0, e_irq = 0, e_viol = 0;
  logic [7:0] e_rdata = 0, e_h2l = 0, e_l2h = 0, m_wd = 0;
  logic [15:0] e_ofs = 0, eff = 0;
  logic [AW-1:0] m_addr = 0;
  logic m_we = 0;
  string tag = "R10";

  always @(posedge clk) begin
    logic irq_set, viol_set;
    irq_set = 0; viol_set = 0;
    if (!rst_n) begin
      ph = 0; e_done = 0; e_req = 0; e_irq = 0; e_viol = 0;
      e_h2l = 0; e_l2h = 0; e_ofs = 0; e_rdata = 0; tag = "R10";
    end else begin
      e_done = 0;
      if (ph != 0) begin
        if (mrdy) begin
          e_done = 1; e_rd = !m_we; tag = "R6";
          if (!m_we) e_rdata = shadow[m_addr[10:0]];
          else shadow[m_addr[10:0]] = m_wd;
          ph = 0;
        end else ph = 2;
      end else if (sel) begin
        e_rd = !we;
        if (addr == 4'd0) begin
          tag = "R8"; e_done = 1;
          if (we) begin e_h2l = wd; irq_set = 1; end else e_rdata = e_h2l;
        end else if (addr == 4'd1) begin
          tag = "R9"; e_done = 1;
          if (!we) e_rdata = e_l2h;
        end else if (addr == 4'd2 || addr == 4'd3) begin
          tag = "R2"; e_done = 1;
          if (we) begin
            if (addr == 4'd2) e_ofs[7:0] = wd; else e_ofs[15:8] = wd;
          end else e_rdata = (addr == 4'd2) ? e_ofs[7:0] : e_ofs[15:8];
        end else if (addr >= 4'd4 && addr <= 4'd7) begin
          eff = e_ofs + 16'(addr - 4'd4);
          if (we ? (eff < WLIM) : (eff < RLIM)) begin
            tag = "R3"; ph = 1; m_we = we; m_wd = wd; m_addr = BASE + eff;
          end else if (we) begin
            tag = "R5"; viol_set = 1; e_done = 1;
          end else begin
            tag = "R4"; e_rdata = 8'hFF; e_done = 1;
          end
        end else begin
          tag = "R1"; e_done = 1;
          if (!we) e_rdata = 8'h00;
        end
      end
      if (irq_set) e_irq = 1; else if (ack) e_irq = 0;
      if (viol_set) e_viol = 1; else if (vclr) e_viol = 0;
      if (l2h_we) e_l2h = l2h_d;
    end
    e_req = (ph == 1);
    #1;
    chk((tag == "R3" || tag == "R6") ? "R6" : "R7", "done", done, e_done);
    if (e_done && e_rd) chk(tag, "rdata", rdata, e_rdata);
    chk(rst_n ? "R6" : "R10", "mem_req", mreq, e_req);
    if (e_req) begin
      chk("R3", "mem_addr", maddr, m_addr);
      chk("R3", "mem_we", mwe, m_we);
      if (m_we) chk("R3", "mem_wdata", mwd, m_wd);
    end
    chk(rst_n ? "R8" : "R10", "irq", irq, e_irq);
    chk(rst_n ? "R5" : "R10", "viol", viol, e_viol);
    chk(rst_n ? "R8" : "R10", "h2l", h2l, e_h2l);
  end

  task automatic io(input logic w, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; we = w; addr = a; wd = d;
    @(negedge clk); sel = 0;
    while (!done) @(negedge clk);
  endtask

  task automatic pulse_ack(); @(negedge clk); ack = 1; @(negedge clk); ack = 0; endtask
  task automatic pulse_vclr(); @(negedge clk); vclr = 1; @(negedge clk); vclr = 0; endtask
  task automatic set_ofs(input logic [15:0] o); io(1, 4'd2, o[7:0]); io(1, 4'd3, o[15:8]); endtask

  initial begin
    for (int i = 0; i < 2048; i++) begin
      bmem[i] = 8'(i * 7 + 3); shadow[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2 pointer
    set_ofs(16'h0010); io(0, 4'd2, 0); io(0, 4'd3, 0);
    set_ofs(16'h1234); io(0, 4'd3, 0); io(0, 4'd2, 0);
    // R3 / R6 reads, several ready delays
    set_ofs(16'h0010);
    for (int n = 0; n < 4; n++) begin delay = n; io(0, 4'(4 + n), 0); end
    delay = 1; io(1, 4'd5, 8'hA5); io(0, 4'd5, 0);
    delay = 3; io(1, 4'd4, 8'h5A); io(0, 4'd4, 0);
    delay = 0; io(1, 4'd7, 8'hC3); io(0, 4'd7, 0);
    // R5 write limit boundary, R4 read side still open
    set_ofs(16'h00FE);
    io(1, 4'd5, 8'h11); io(1, 4'd6, 8'h22); io(0, 4'd6, 0); io(0, 4'd7, 0);
    pulse_vclr(); io(0, 4'd5, 0);
    // violation and clear in the same cycle: set wins
    @(negedge clk); sel = 1; we = 1; addr = 4'd7; wd = 8'h33; vclr = 1;
    @(negedge clk); sel = 0; vclr = 0;
    repeat (2) @(negedge clk);
    pulse_vclr();
    // R4 read limit boundary
    set_ofs(16'h01FD);
    io(0, 4'd6, 0); io(0, 4'd7, 0); io(1, 4'd4, 8'h44);
    set_ofs(16'h0300); io(0, 4'd4, 0);
    pulse_vclr();
    // R3 pointer wrap
    set_ofs(16'hFFFE); io(0, 4'd7, 0); io(1, 4'd6, 8'h99); io(0, 4'd6, 0);
    // R8 mailbox
    io(1, 4'd0, 8'h3C); io(0, 4'd0, 0); repeat (2) @(negedge clk);
    pulse_ack();
    @(negedge clk); sel = 1; we = 1; addr = 4'd0; wd = 8'hE1; ack = 1;
    @(negedge clk); sel = 0; ack = 0;
    repeat (2) @(negedge clk); pulse_ack();
    // R9 local-to-host byte
    @(negedge clk); l2h_we = 1; l2h_d = 8'h77;
    @(negedge clk); l2h_we = 0;
    io(0, 4'd1, 0); io(1, 4'd1, 8'h55); io(0, 4'd1, 0);
    // R1 unmapped
    io(0, 4'd9, 0); io(1, 4'd12, 8'hEE); io(0, 4'd12, 0); io(0, 4'd15, 0);
    io(0, 4'd2, 0); io(0, 4'd0, 0);
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 50000) begin
      checks++; fails++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule